// File: doc/BRIEF.md
# Bus Selection Detector and Interrupt Combiner

This block turns the interrupt causes of a parallel-bus device controller into one sticky interrupt request. One cause comes from inside the block. A selection detector watches the bus select, busy and input/output lines and the data-bus ID bits. It reports a selection when the select line is asserted, busy is released and at least one data bit matches the programmed ID mask, and all three conditions hold for a settle time given in clock cycles. The level of the input/output line at that moment decides whether the event is recorded as a plain selection or as a reselection.

The other causes arrive as single-cycle event strobes from neighbouring logic: end of a DMA process, bus reset, data parity error, phase mismatch and disconnection. Each strobe has its own enable bit. Software clears the request with a status-clear read strobe. An external reset level that stays asserted for a qualification time in clock cycles also clears it. When parity checking is enabled, a selection seen while the parity-error status is set is discarded.

Top module: `selirq_unit`

## Requirements
- R1: After `rst_n` is asserted, `irq`, `sel_last` and `resel_last` are all 0.
- R2: A selection sets `irq` at the clock edge that ends the SETTLE_CYC-th consecutive cycle in which `bus_sel`=1, `bus_bsy`=0 and (`bus_data` & `sel_mask`) is non-zero. At any earlier edge `irq` stays 0.
- R3: A single data bit that overlaps the mask is enough for an ID match, whatever the other data bits are.
- R4: A qualified selection with `bus_io`=0 sets `sel_last`=1 and `resel_last`=0. With `bus_io`=1 it sets `resel_last`=1 and `sel_last`=0. The two flags are never 1 together.
- R5: When `sel_mask` is all zeros, no selection is detected.
- R6: If any selection condition drops before the settle time has elapsed, the count starts again from zero.
- R7: With `par_chk_en`=1 and `par_err`=1, a qualified selection changes neither `irq` nor the flags. With `par_chk_en`=0, `par_err` has no effect.
- R8: Bit i of `src_evt` sets `irq` at the next edge only when `src_en[i]`=1. The bit order is 0 end of DMA process, 1 bus reset, 2 parity error, 3 phase mismatch, 4 disconnection. A disabled source leaves `irq` unchanged.
- R9: A `clr_rd` strobe with no new cause in the same cycle clears `irq`, `sel_last` and `resel_last` at the next edge.
- R10: If an enabled source or a selection fires in the same cycle as `clr_rd`, `irq` is 1 after that edge.
- R11: When `ext_rst` has been 1 for RST_CYC consecutive cycles, `irq` and both flags clear at the edge that ends the RST_CYC-th cycle. They stay clear, ignoring all causes, while `ext_rst` remains 1. A shorter pulse has no effect.
- R12: One continuous qualifying selection produces a single event. Once `irq` is cleared while the conditions stay asserted, it is not set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_sel | input | 1 | Bus select line, 1 = asserted |
| bus_bsy | input | 1 | Bus busy line, 1 = asserted |
| bus_io | input | 1 | Bus input/output line, 1 = asserted (reselection) |
| bus_data | input | ID_W | Data-bus ID bits |
| sel_mask | input | ID_W | Select-enable mask; zero disables selection |
| par_chk_en | input | 1 | Parity checking enable (mode bit) |
| par_err | input | 1 | Parity-error status bit |
| src_evt | input | N_SRC | Event strobes from other interrupt causes |
| src_en | input | N_SRC | Per-source interrupt enables |
| clr_rd | input | 1 | Status-clear read strobe |
| ext_rst | input | 1 | External reset level, 1 = asserted |
| irq | output | 1 | Sticky interrupt request |
| sel_last | output | 1 | Last recorded event was a selection |
| resel_last | output | 1 | Last recorded event was a reselection |

## Verification
The clear read can land in the same cycle as a new cause, and the block must let the new cause win. The bench provokes this by raising an enabled event strobe on the same falling edge as `clr_rd`, then confirms at the next falling edge that `irq` is still 1. A second collision pairs a set `irq` with a qualified external reset. The bench holds `ext_rst` one cycle short of the qualification time, confirms that `irq` is still set, and then confirms that it clears on the next cycle and stays clear even when an event fires while the reset is held.

// File: rtl/selirq_pkg.sv
package selirq_pkg;
  // Source index order of src_evt / src_en
  localparam int SRC_EOP   = 0;
  localparam int SRC_BRST  = 1;
  localparam int SRC_PAR   = 2;
  localparam int SRC_PHASE = 3;
  localparam int SRC_DISC  = 4;
  localparam int N_SRC     = 5;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_SEL   = 2'b01,
    KIND_RESEL = 2'b10
  } sel_kind_e;
endpackage

// File: rtl/selirq_hold_qual.sv
// Counts consecutive cycles of an input level. LEVEL=0 gives a single
// pulse in the CYC-th cycle; LEVEL=1 gives a level from that cycle onward.
module selirq_hold_qual #(
  parameter int CYC   = 4,
  parameter bit LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_lvl,
  output logic q_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);
  localparam logic [CW-1:0] SAT  = CW'(CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = in_lvl | (cnt_q != '0);
    if (!in_lvl)
      cnt_d = '0;
    else if (cnt_q != SAT)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  generate
    if (LEVEL) begin : g_level
      assign q_o = in_lvl & (cnt_q >= LAST);
    end else begin : g_pulse
      assign q_o = in_lvl & (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/selirq_match.sv
// Selection condition: select asserted, busy released, any ID bit matching.
module selirq_match #(
  parameter int ID_W = 8
) (
  input  logic            bus_sel,
  input  logic            bus_bsy,
  input  logic [ID_W-1:0] bus_data,
  input  logic [ID_W-1:0] sel_mask,
  output logic            cond_o
);
  logic [ID_W-1:0] hit;

  always_comb begin
    hit    = bus_data & sel_mask;
    cond_o = bus_sel & ~bus_bsy & (|hit);
  end
endmodule

// File: rtl/selirq_core.sv
module selirq_core #(
  parameter int N_SRC = selirq_pkg::N_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fire,
  input  logic             bus_io,
  input  logic             par_chk_en,
  input  logic             par_err,
  input  logic [N_SRC-1:0] src_evt,
  input  logic [N_SRC-1:0] src_en,
  input  logic             clr_rd,
  input  logic             rst_held,
  output logic             irq,
  output selirq_pkg::sel_kind_e kind
);
  import selirq_pkg::*;

  logic [N_SRC-1:0] gated;
  logic             sel_ok, set_any;
  logic             irq_q, irq_d, irq_en;
  sel_kind_e        kind_q, kind_d;
  logic             kind_en;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign gated[i] = src_evt[i] & src_en[i];
    end
  endgenerate

  always_comb begin
    sel_ok  = sel_fire & ~(par_chk_en & par_err);
    set_any = sel_ok | (|gated);

    // priority: qualified external reset, new cause, clear read
    if (rst_held)
      irq_d = 1'b0;
    else if (set_any)
      irq_d = 1'b1;
    else if (clr_rd)
      irq_d = 1'b0;
    else
      irq_d = irq_q;
    irq_en = rst_held | set_any | clr_rd;

    if (rst_held)
      kind_d = KIND_NONE;
    else if (sel_ok)
      kind_d = bus_io ? KIND_RESEL : KIND_SEL;
    else if (clr_rd)
      kind_d = KIND_NONE;
    else
      kind_d = kind_q;
    kind_en = rst_held | sel_ok | clr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else if (irq_en)
      irq_q <= irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      kind_q <= KIND_NONE;
    else if (kind_en)
      kind_q <= kind_d;
  end

  assign irq  = irq_q;
  assign kind = kind_q;
endmodule

// File: rtl/selirq_unit.sv
module selirq_unit #(
  parameter int ID_W       = 8,
  parameter int N_SRC      = selirq_pkg::N_SRC,
  parameter int SETTLE_CYC = 4,
  parameter int RST_CYC    = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_bsy,
  input  logic             bus_io,
  input  logic [ID_W-1:0]  bus_data,
  input  logic [ID_W-1:0]  sel_mask,
  input  logic             par_chk_en,
  input  logic             par_err,
  input  logic [N_SRC-1:0] src_evt,
  input  logic [N_SRC-1:0] src_en,
  input  logic             clr_rd,
  input  logic             ext_rst,
  output logic             irq,
  output logic             sel_last,
  output logic             resel_last
);
  import selirq_pkg::*;

  logic      sel_cond, sel_fire, rst_held;
  sel_kind_e kind;

  selirq_match #(.ID_W(ID_W)) u_match (
    .bus_sel  (bus_sel),
    .bus_bsy  (bus_bsy),
    .bus_data (bus_data),
    .sel_mask (sel_mask),
    .cond_o   (sel_cond)
  );

  selirq_hold_qual #(.CYC(SETTLE_CYC), .LEVEL(1'b0)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_lvl (sel_cond),
    .q_o    (sel_fire)
  );

  selirq_hold_qual #(.CYC(RST_CYC), .LEVEL(1'b1)) u_rstq (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_lvl (ext_rst),
    .q_o    (rst_held)
  );

  selirq_core #(.N_SRC(N_SRC)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_fire   (sel_fire),
    .bus_io     (bus_io),
    .par_chk_en (par_chk_en),
    .par_err    (par_err),
    .src_evt    (src_evt),
    .src_en     (src_en),
    .clr_rd     (clr_rd),
    .rst_held   (rst_held),
    .irq        (irq),
    .kind       (kind)
  );

  assign sel_last   = (kind == KIND_SEL);
  assign resel_last = (kind == KIND_RESEL);
endmodule

// File: rtl/selirq_checks.sv
module selirq_checks #(
  parameter int ID_W  = 8,
  parameter int N_SRC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ID_W-1:0]  sel_mask,
  input logic             par_chk_en,
  input logic             par_err,
  input logic [N_SRC-1:0] src_evt,
  input logic [N_SRC-1:0] src_en,
  input logic             clr_rd,
  input logic             sel_fire,
  input logic             rst_held,
  input logic             irq,
  input logic             sel_last,
  input logic             resel_last
);
  logic src_any;
  assign src_any = |(src_evt & src_en);

  a_r4_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_last && resel_last));

  a_r5_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mask == '0) |-> !sel_fire);

  a_r7_par_block: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fire && par_chk_en && par_err && !src_any && !irq && !rst_held)
      |=> !irq);

  a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sel_fire || src_any));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !rst_held && !sel_fire && !src_any)
      |=> (!irq && !sel_last && !resel_last));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (src_any && !rst_held) |=> irq);

  a_r11_ext_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_held |=> (!irq && !sel_last && !resel_last));
endmodule

bind selirq_unit selirq_checks #(.ID_W(ID_W), .N_SRC(N_SRC)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_mask   (sel_mask),
  .par_chk_en (par_chk_en),
  .par_err    (par_err),
  .src_evt    (src_evt),
  .src_en     (src_en),
  .clr_rd     (clr_rd),
  .sel_fire   (sel_fire),
  .rst_held   (rst_held),
  .irq        (irq),
  .sel_last   (sel_last),
  .resel_last (resel_last)
);

// File: tb/test_selirq_unit.sv
`timescale 1ns/1ps
module test_selirq_unit;
  localparam int ID_W = 8, N_SRC = 5, SETTLE = 4, RSTC = 50;

  logic clk, rst_n, bus_sel, bus_bsy, bus_io, par_chk_en, par_err, clr_rd, ext_rst;
  logic [ID_W-1:0]  bus_data, sel_mask;
  logic [N_SRC-1:0] src_evt, src_en;
  logic irq, sel_last, resel_last;

  selirq_unit #(.ID_W(ID_W), .N_SRC(N_SRC), .SETTLE_CYC(SETTLE), .RST_CYC(RSTC)) i_selirq_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_bsy(bus_bsy), .bus_io(bus_io),
    .bus_data(bus_data), .sel_mask(sel_mask), .par_chk_en(par_chk_en), .par_err(par_err),
    .src_evt(src_evt), .src_en(src_en), .clr_rd(clr_rd), .ext_rst(ext_rst),
    .irq(irq), .sel_last(sel_last), .resel_last(resel_last));

  typedef struct { logic i; logic s; logic r; string tag; } exp_t;
  exp_t q[$];
  exp_t mon_e;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: pops expectations and compares against outputs
  initial begin
    forever begin
      wait (q.size() != 0);
      mon_e = q.pop_front();
      n_chk++;
      if ({irq, sel_last, resel_last} !== {mon_e.i, mon_e.s, mon_e.r}) begin
        n_err++;
        $display("FAIL %s: got irq=%0b sel=%0b resel=%0b expected irq=%0b sel=%0b resel=%0b",
                 mon_e.tag, irq, sel_last, resel_last, mon_e.i, mon_e.s, mon_e.r);
      end
    end
  end

  task automatic expect_out(input logic i, input logic s, input logic r, input string tag);
    exp_t e;
    e.i = i; e.s = s; e.r = r; e.tag = tag;
    q.push_back(e);
    #0.5;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_pulse();
    clr_rd = 1'b1; tick(1); clr_rd = 1'b0;
  endtask

  task automatic event_pulse(input int idx);
    src_evt = N_SRC'(1) << idx; tick(1); src_evt = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_bsy = 0; bus_io = 0; bus_data = '0;
    sel_mask = 8'h10; par_chk_en = 0; par_err = 0; src_evt = '0; src_en = '1;
    clr_rd = 0; ext_rst = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_out(0, 0, 0, "R1 reset state");

    // R2/R3: selection qualifies after SETTLE cycles, one overlapping bit
    bus_sel = 1; bus_data = 8'h31;
    tick(SETTLE - 1);
    expect_out(0, 0, 0, "R2 not before settle");
    tick(1);
    expect_out(1, 1, 0, "R2 R3 selection after settle");
    clear_pulse();
    expect_out(0, 0, 0, "R9 clear read");
    tick(6);
    expect_out(0, 0, 0, "R12 no re-trigger while held");
    bus_sel = 0; tick(1);

    // R4: reselection
    bus_io = 1; bus_data = 8'h10; bus_sel = 1;
    tick(SETTLE);
    expect_out(1, 0, 1, "R4 reselection flag");
    bus_sel = 0; bus_io = 0; clear_pulse();
    expect_out(0, 0, 0, "R9 clear after reselection");

    // R5: zero mask
    sel_mask = '0; bus_data = 8'hFF; bus_sel = 1;
    tick(8);
    expect_out(0, 0, 0, "R5 zero mask disables");
    bus_sel = 0; sel_mask = 8'h10; bus_data = 8'h10; tick(1);

    // R6: busy held, then interrupted sequence
    bus_sel = 1; bus_bsy = 1;
    tick(6);
    expect_out(0, 0, 0, "R6 busy blocks");
    bus_bsy = 0; tick(2);
    bus_sel = 0; tick(1);
    bus_sel = 1; tick(SETTLE - 1);
    expect_out(0, 0, 0, "R6 count restarted");
    tick(1);
    expect_out(1, 1, 0, "R6 qualifies after full run");
    bus_sel = 0; clear_pulse();

    // R7: parity gate
    par_chk_en = 1; par_err = 1; bus_sel = 1;
    tick(6);
    expect_out(0, 0, 0, "R7 parity error blocks");
    bus_sel = 0; tick(1);
    par_chk_en = 0; bus_sel = 1;
    tick(SETTLE);
    expect_out(1, 1, 0, "R7 parity ignored when disabled");
    bus_sel = 0; par_err = 0; clear_pulse();

    // R8: each source, enabled and disabled
    for (int k = 0; k < N_SRC; k++) begin
      src_en = '1;
      event_pulse(k);
      expect_out(1, 0, 0, $sformatf("R8 source %0d enabled", k));
      clear_pulse();
      src_en = ~(N_SRC'(1) << k);
      event_pulse(k);
      expect_out(0, 0, 0, $sformatf("R8 source %0d disabled", k));
    end
    src_en = '1;

    // R10: event in same cycle as clear read
    event_pulse(0);
    src_evt = N_SRC'(1) << 2; clr_rd = 1; tick(1); src_evt = '0; clr_rd = 0;
    expect_out(1, 0, 0, "R10 new cause wins over clear");
    clear_pulse();
    expect_out(0, 0, 0, "R10 later clear works");

    // R11: external reset qualification
    bus_sel = 1; tick(SETTLE); bus_sel = 0;
    ext_rst = 1;
    tick(RSTC - 1);
    expect_out(1, 1, 0, "R11 not cleared before qualification");
    tick(1);
    expect_out(0, 0, 0, "R11 cleared after qualification");
    event_pulse(3);
    expect_out(0, 0, 0, "R11 events ignored while held");
    ext_rst = 0; tick(1);
    event_pulse(4);
    ext_rst = 1; tick(10); ext_rst = 0; tick(1);
    expect_out(1, 0, 0, "R11 short pulse no effect");

    wait (q.size() == 0);
    #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule